// File: doc/BRIEF.md
# Effective Address Mode Decoder

This block takes the 6-bit mode/register field of an instruction operand, together with the operand size in bytes, and works out which addressing form is meant. It reports a register number and a set of form flags. For forms that carry trailing extension words, it pulls those 16-bit words from an instruction-word stream and assembles them into a displacement, an absolute address or an immediate value of up to 96 bits.

A pulse on `start` while the block is idle latches the field and the size. Forms with no trailing words complete at once. Other forms raise `busy` and accept words through a valid/ready handshake until they have the count they need. A one-cycle `done` pulse marks the end, and at that point `advance` holds the number of words taken. A fetch error reported with a word stops the operation and produces a `fault` pulse in place of `done`.

Full indexed-extension handling belongs to a separate unit. The indexed forms are classified here and consume no words. The block performs no memory access.

Top module: `ea_decoder`

## Requirements
- R1: When field bits [5:3] are 000 or 001, `reg_num` is field bits [3:0]. For every other field value, `reg_num` is 8 plus field bits [2:0].
- R2: `flags` uses these bits: [0] register direct, [1] immediate, [2] postincrement, [3] predecrement, [4] displacement, [5] indexed, [6] absolute, [7] PC-relative. Field bits [5:3] select the form: 0 or 1 gives bit 0; 2 (indirect) gives no bits; 3 gives bit 2; 4 gives bit 3; 5 gives bit 4 and takes one word; 6 gives bit 5.
- R3: When field bits [5:3] are 7, field bits [2:0] select the form. 0 gives bit 6 with one word; 1 gives bit 6 with two words; 2 gives bits 7 and 4 with one word; 3 gives bits 7 and 5 with no words; 4 gives bit 1 (immediate).
- R4: Field values 075, 076 and 077 octal are illegal. So is immediate with a size outside {1, 2, 4, 8, 12}. An illegal field completes with `done` and `illegal` high the cycle after start, with `flags` 0, `advance` 0 and `value` 0.
- R5: A single-word displacement or short absolute address is sign-extended from bit 15 into `value[31:0]`. The upper bits of `value` are 0.
- R6: A two-word absolute address places the first word in `value[31:16]` and the second in `value[15:0]`.
- R7: For a 1-byte immediate, the block takes one word and sign-extends its low 8 bits to 32. For a 2-byte immediate, it takes one word and sign-extends it from bit 15.
- R8: Immediates of 4, 8 and 12 bytes take 2, 4 and 6 words. Word k goes to 32-bit slot k/2 (slot s at `value[32s+31:32s]`), in the upper half when k is even and in the lower half when k is odd.
- R9: Forms that take no words complete with `done` high the cycle after start, with `advance` 0 and `value` 0, and without raising `busy`.
- R10: `word_ready` is high exactly while `busy` is high. Every accepted word increments `advance`. `done` is high for the one cycle after the last word is accepted, and `busy` falls at the same time.
- R11: A word presented with `word_err` high while busy is not counted. It ends the operation with a one-cycle `fault` pulse, `busy` low and no `done`.
- R12: `start` while `busy` is high is ignored. The latched register number, flags and word count of the operation in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a decode (ignored while busy) |
| modreg | input | 6 | Mode/register field |
| opsize | input | 4 | Operand size in bytes |
| word_valid | input | 1 | Extension word offered |
| word_data | input | 16 | Extension word |
| word_err | input | 1 | Fetch error on the offered word |
| word_ready | output | 1 | Word accepted this cycle if valid |
| busy | output | 1 | Fetching extension words |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle abort pulse |
| illegal | output | 1 | Field was illegal |
| reg_num | output | 4 | Register number |
| flags | output | 8 | Form flags |
| value | output | 96 | Assembled extension value |
| advance | output | 3 | Words consumed |

## Verification
The bench goes after the sign boundary of each short form, using words 0x8000, 0x7FFE and a byte immediate whose bit 7 is set but whose bit 15 is clear. A design that extended from the wrong bit would show wrong upper bits in `value`. The multi-word immediates are fed with idle gaps so that swapped halves or swapped slots show as a wrong `value`. A miscounted word budget would end early or hang, which shows as `done` in the wrong cycle. A fetch error is injected on the first word and in mid-stream, where a design that counted the bad word or still raised `done` would be caught. A `start` issued in mid-fetch exposes a design that re-latched its field.

// File: rtl/ea_decoder.sv
module ea_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  modreg,
  input  logic [3:0]  opsize,
  input  logic        word_valid,
  input  logic [15:0] word_data,
  input  logic        word_err,
  output logic        word_ready,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic        illegal,
  output logic [3:0]  reg_num,
  output logic [7:0]  flags,
  output logic [95:0] value,
  output logic [2:0]  advance
);
  localparam int F_DIR = 0, F_IMM = 1, F_POST = 2, F_PRE = 3;
  localparam int F_OFS = 4, F_IDX = 5, F_ABS = 6, F_PC = 7;
  localparam logic [1:0] K_RAW = 2'd0, K_SX16 = 2'd1, K_SX8 = 2'd2;

  logic [3:0]  d_reg;
  logic [7:0]  d_flags;
  logic [2:0]  d_words;
  logic [1:0]  d_kind;
  logic        d_ill;

  logic        busy_q, done_q, fault_q, ill_q;
  logic [3:0]  reg_q;
  logic [7:0]  flags_q;
  logic [2:0]  need_q, cnt_q;
  logic [1:0]  kind_q;
  logic [95:0] value_q, nxt_val;
  logic [6:0]  pos;

  always_comb begin
    d_reg   = {1'b1, modreg[2:0]};
    d_flags = '0;
    d_words = '0;
    d_kind  = K_RAW;
    d_ill   = 1'b0;
    case (modreg[5:3])
      3'd0, 3'd1: begin d_reg = modreg[3:0]; d_flags[F_DIR] = 1'b1; end
      3'd2: ;
      3'd3: d_flags[F_POST] = 1'b1;
      3'd4: d_flags[F_PRE] = 1'b1;
      3'd5: begin d_flags[F_OFS] = 1'b1; d_words = 3'd1; d_kind = K_SX16; end
      3'd6: d_flags[F_IDX] = 1'b1;
      default: begin
        case (modreg[2:0])
          3'd0: begin d_flags[F_ABS] = 1'b1; d_words = 3'd1; d_kind = K_SX16; end
          3'd1: begin d_flags[F_ABS] = 1'b1; d_words = 3'd2; end
          3'd2: begin d_flags[F_PC] = 1'b1; d_flags[F_OFS] = 1'b1; d_words = 3'd1; d_kind = K_SX16; end
          3'd3: begin d_flags[F_PC] = 1'b1; d_flags[F_IDX] = 1'b1; end
          3'd4: begin
            d_flags[F_IMM] = 1'b1;
            case (opsize)
              4'd1:  begin d_words = 3'd1; d_kind = K_SX8; end
              4'd2:  begin d_words = 3'd1; d_kind = K_SX16; end
              4'd4:  d_words = 3'd2;
              4'd8:  d_words = 3'd4;
              4'd12: d_words = 3'd6;
              default: begin d_ill = 1'b1; d_flags = '0; end
            endcase
          end
          default: d_ill = 1'b1;
        endcase
      end
    endcase
  end

  assign pos = {cnt_q[2:1], 5'b0} + (cnt_q[0] ? 7'd0 : 7'd16);

  always_comb begin
    nxt_val = value_q;
    nxt_val[pos +: 16] = word_data;
    if (kind_q == K_SX16) nxt_val = {64'b0, {16{word_data[15]}}, word_data};
    else if (kind_q == K_SX8) nxt_val = {64'b0, {24{word_data[7]}}, word_data[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; fault_q <= 1'b0; ill_q <= 1'b0;
      reg_q <= '0; flags_q <= '0; need_q <= '0; cnt_q <= '0;
      kind_q <= K_RAW; value_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (!busy_q && start) begin
        reg_q   <= d_reg;
        flags_q <= d_flags;
        ill_q   <= d_ill;
        kind_q  <= d_kind;
        need_q  <= d_words;
        cnt_q   <= '0;
        value_q <= '0;
        if (d_words == 3'd0) done_q <= 1'b1;
        else busy_q <= 1'b1;
      end else if (busy_q && word_valid) begin
        if (word_err) begin
          busy_q  <= 1'b0;
          fault_q <= 1'b1;
        end else begin
          cnt_q   <= cnt_q + 3'd1;
          value_q <= nxt_val;
          if (cnt_q + 3'd1 == need_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign word_ready = busy_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign fault   = fault_q;
  assign illegal = ill_q;
  assign reg_num = reg_q;
  assign flags   = flags_q;
  assign value   = value_q;
  assign advance = cnt_q;

  assert_word_counted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && word_valid && !word_err |=> advance == $past(advance) + 3'd1);
  assert_fault_needs_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(busy && word_valid && word_err));
  assert_fault_no_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !done && !busy);
  assert_illegal_no_words_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && illegal |-> advance == 3'd0 && flags == 8'd0);
  assert_start_progress_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> done || busy);
  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(reg_num) && $stable(flags));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> advance <= 3'd5);
endmodule

// File: tb/ea_decoder_bench.sv
module ea_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, word_valid = 1'b0, word_err = 1'b0;
  logic [5:0] modreg = '0;
  logic [3:0] opsize = '0;
  logic [15:0] word_data = '0;
  logic word_ready, busy, done, fault, illegal;
  logic [3:0] reg_num;
  logic [7:0] flags;
  logic [95:0] value;
  logic [2:0] advance;
  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] wq [6];

  always #5 clk = ~clk;

  ea_decoder u_ea_decoder (.clk(clk), .rst_n(rst_n), .start(start), .modreg(modreg),
    .opsize(opsize), .word_valid(word_valid), .word_data(word_data), .word_err(word_err),
    .word_ready(word_ready), .busy(busy), .done(done), .fault(fault), .illegal(illegal),
    .reg_num(reg_num), .flags(flags), .value(value), .advance(advance));

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog act=%0d exp=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference decode, from R1-style rules
  task automatic ref_decode(input logic [5:0] mr, input logic [3:0] sz,
      output logic [3:0] r, output logic [7:0] f, output int n, output int kind, output bit ill);
    int m = int'(mr[5:3]), s = int'(mr[2:0]);
    r = (m <= 1) ? mr[3:0] : 4'(8 + s);
    f = 0; n = 0; kind = 0; ill = 0;
    if (m <= 1) f = 8'h01;
    else if (m == 3) f = 8'h04;
    else if (m == 4) f = 8'h08;
    else if (m == 5) begin f = 8'h10; n = 1; kind = 1; end
    else if (m == 6) f = 8'h20;
    else if (m == 7) begin
      if (s == 0) begin f = 8'h40; n = 1; kind = 1; end
      else if (s == 1) begin f = 8'h40; n = 2; end
      else if (s == 2) begin f = 8'h90; n = 1; kind = 1; end
      else if (s == 3) f = 8'hA0;
      else if (s == 4) begin
        f = 8'h02;
        if (sz == 1) begin n = 1; kind = 2; end
        else if (sz == 2) begin n = 1; kind = 1; end
        else if (sz == 4) n = 2;
        else if (sz == 8) n = 4;
        else if (sz == 12) n = 6;
        else begin ill = 1; f = 0; end
      end else ill = 1;
    end
  endtask

  function automatic logic [95:0] ref_value(input int n, input int kind);
    logic [95:0] v = '0;
    if (kind == 1) begin
      v[31:0] = 32'(signed'(wq[0]));
    end else if (kind == 2) begin
      v[31:0] = 32'(signed'(wq[0][7:0]));
    end else begin
      for (int k = 0; k < n; k++)
        v = v | (96'(wq[k]) << (32 * (k / 2) + ((k % 2) ? 0 : 16)));
    end
    return v;
  endfunction

  task automatic op(input string tag, input logic [5:0] mr, input logic [3:0] sz,
      input int gap, input int err_at, input bit poke);
    logic [3:0] er; logic [7:0] ef; int n, kind; bit ill;
    ref_decode(mr, sz, er, ef, n, kind, ill);
    @(negedge clk);
    start = 1'b1; modreg = mr; opsize = sz;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk({tag, " R9 done"}, 96'(done), 96'(1));
      chk({tag, " R9 busy"}, 96'(busy), 96'(0));
      chk({tag, " R1 reg"}, 96'(reg_num), 96'(er));
      chk({tag, " R2 flags"}, 96'(flags), 96'(ef));
      chk({tag, " R4 illegal"}, 96'(illegal), 96'(ill));
      chk({tag, " R9 value"}, value, 96'(0));
      chk({tag, " R9 advance"}, 96'(advance), 96'(0));
      @(negedge clk);
      chk({tag, " R10 done pulse"}, 96'(done), 96'(0));
      return;
    end
    chk({tag, " R10 busy"}, 96'(busy), 96'(1));
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < gap; g++) begin
        if (poke && k == 1 && g == 0) begin start = 1'b1; modreg = 6'o05; opsize = 4'd4; end
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R10 ready"}, 96'(word_ready), 96'(1));
        chk({tag, " R10 no early done"}, 96'(done), 96'(0));
      end
      word_valid = 1'b1; word_data = wq[k]; word_err = (k == err_at);
      @(negedge clk);
      word_valid = 1'b0; word_err = 1'b0;
      if (k == err_at) begin
        chk({tag, " R11 fault"}, 96'(fault), 96'(1));
        chk({tag, " R11 no done"}, 96'(done), 96'(0));
        chk({tag, " R11 busy"}, 96'(busy), 96'(0));
        chk({tag, " R11 advance"}, 96'(advance), 96'(k));
        return;
      end
      chk({tag, " R10 advance"}, 96'(advance), 96'(k + 1));
      if (k == n - 1) begin
        chk({tag, " R10 done"}, 96'(done), 96'(1));
        chk({tag, " R10 ready low"}, 96'(word_ready), 96'(0));
        chk({tag, " R1 reg"}, 96'(reg_num), 96'(er));
        chk({tag, " R3 flags"}, 96'(flags), 96'(ef));
        chk({tag, " R8 value"}, value, ref_value(n, kind));
        if (poke) chk({tag, " R12 reg kept"}, 96'(reg_num), 96'(er));
      end else begin
        chk({tag, " R10 busy mid"}, 96'(busy), 96'(1));
        chk({tag, " R10 done mid"}, 96'(done), 96'(0));
      end
    end
    @(negedge clk);
    chk({tag, " R10 done pulse"}, 96'(done), 96'(0));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("reset done", 96'(done), 96'(0));
    chk("reset busy", 96'(busy), 96'(0));
    chk("reset ready R10", 96'(word_ready), 96'(0));
    chk("reset value", value, 96'(0));
    rst_n = 1'b1;
    wq[0] = 16'h8000; wq[1] = 16'h1234; wq[2] = 16'hfedc;
    wq[3] = 16'h0077; wq[4] = 16'habcd; wq[5] = 16'h5a5a;
    op("d3 R1", 6'o03, 4'd4, 0, -1, 0);
    op("a2 R1", 6'o12, 4'd4, 0, -1, 0);
    op("ind R2", 6'o25, 4'd4, 0, -1, 0);
    op("post R2", 6'o31, 4'd4, 0, -1, 0);
    op("pre R2", 6'o47, 4'd4, 0, -1, 0);
    op("idx R2", 6'o61, 4'd4, 0, -1, 0);
    op("pcidx R3", 6'o73, 4'd4, 0, -1, 0);
    op("disp R5", 6'o52, 4'd4, 2, -1, 0);
    op("abs16 R5", 6'o70, 4'd4, 0, -1, 0);
    op("abs32 R6", 6'o71, 4'd4, 1, -1, 0);
    op("poke R12", 6'o71, 4'd4, 2, -1, 1);
    wq[0] = 16'h7ffe;
    op("abs16pos R5", 6'o70, 4'd4, 0, -1, 0);
    wq[0] = 16'hfffe;
    op("pcrel R5", 6'o72, 4'd4, 0, -1, 0);
    wq[0] = 16'h1280;
    op("imm1 R7", 6'o74, 4'd1, 0, -1, 0);
    wq[0] = 16'h0a7f;
    op("imm1pos R7", 6'o74, 4'd1, 1, -1, 0);
    wq[0] = 16'h8001;
    op("imm2 R7", 6'o74, 4'd2, 0, -1, 0);
    op("imm4 R8", 6'o74, 4'd4, 1, -1, 0);
    op("imm8 R8", 6'o74, 4'd8, 0, -1, 0);
    op("imm12 R8", 6'o74, 4'd12, 2, -1, 0);
    op("ill75 R4", 6'o75, 4'd4, 0, -1, 0);
    op("ill76 R4", 6'o76, 4'd4, 0, -1, 0);
    op("ill77 R4", 6'o77, 4'd4, 0, -1, 0);
    op("immsz R4", 6'o74, 4'd3, 0, -1, 0);
    op("err mid R11", 6'o74, 4'd12, 1, 3, 0);
    op("err first R11", 6'o71, 4'd4, 0, 0, 0);
    op("after err R9", 6'o20, 4'd4, 0, -1, 0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule